// File: doc/BRIEF.md
# I2C Target Controller with Host Status Flags

This block answers an I2C bus as a target. It samples SCL and SDA on the system clock and recognises START, repeated START and STOP conditions. It compares each address byte with a 7-bit own address taken from a port, and then moves data one byte at a time in whichever direction the master asked for. A small register-style host port gives access to a status word, a receive holding register and a transmit holding register. SDA is open-drain: the block asserts `sda_oe_o` to pull the line low and never drives it high.

The host learns about a transfer from the status flags. An access-active flag is set when the address matches. A direction flag is loaded from the R/W bit at the same point, and it has meaning only while access is active. An end-of-access flag records that a transfer has ended. The receive-ready and transmit-ready flags follow the movement of bytes between the shift register and the holding registers. If the master reads while the transmit holding register is empty, the block sends an all-ones byte and records an underrun.

Top module: `i2c_target`

## Requirements
- R1: After reset, SDA is released (`sda_oe_o`=0) and the status word at register 0 reads 0x10. The status bits are: bit0 access active, bit1 direction (1 = master read), bit2 end of access, bit3 receive ready, bit4 transmit ready, bit5 underrun. Register 1 is receive data (read) and register 2 is transmit data (write).
- R2: When an address byte that follows a START or repeated START carries the own address, the target pulls SDA low for the ninth clock, sets access active and loads the direction bit from the R/W bit.
- R3: When the address byte carries any other address, the target leaves SDA released for the ninth clock and access active stays or becomes clear.
- R4: During a master write, each byte is copied to the receive data register at the end of its eighth bit, receive ready sets, and the target acknowledges the byte. A host read of register 1 returns the byte and clears receive ready.
- R5: A STOP clears access active. If access was active, end of access sets. A host read of register 0 clears end of access and underrun.
- R6: A repeated START followed by the own address keeps access active and reloads the direction bit. A repeated START followed by another address clears access active and sets end of access.
- R7: During a master read, the transmit data register is copied to the shift register when a byte starts, and transmit ready clears at that point. Bits go out MSB first. Transmit ready sets again during the master's acknowledge bit, whether that bit is ACK or NACK.
- R8: If the transmit data register is empty when a read byte starts, the target sends 0xFF and sets underrun.
- R9: After the master answers a read byte with NACK, the target drives SDA on no further clock until the next START or repeated START.
- R10: `sda_oe_o` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | Pulls SDA low when high |
| own_addr_i | input | 7 | Own 7-bit target address |
| reg_addr_i | input | 2 | Host register select |
| reg_rd_i | input | 1 | Host read strobe; read side effects take place on this cycle |
| reg_wr_i | input | 1 | Host write strobe |
| reg_wdata_i | input | 8 | Host write data |
| reg_rdata_o | output | 8 | Host read data, combinational from reg_addr_i |

## Verification
The bench builds the block with its default parameters: 8-bit data, a two-stage synchronizer and a 2-bit register select. It holds each SCL quarter period at ten system clocks, so the synchronizer latency fits well inside one phase. With own address 0x2A and foreign addresses 0x15 and 0x11, the bench covers matching and non-matching addresses on both a fresh START and a repeated START. It also covers a multi-byte write, a read that runs from a full holding register into an underrun, and dead clocks after a master NACK. On every clock the bench checks that the SDA enable only moves while SCL is low.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACK, ST_WR, ST_RD, ST_RACK
  } tgt_state_e;

  // status word bit positions
  localparam int STS_ACT   = 0;
  localparam int STS_DIR   = 1;
  localparam int STS_EOA   = 2;
  localparam int STS_RXRDY = 3;
  localparam int STS_TXRDY = 4;
  localparam int STS_UNDR  = 5;

  // host register map
  localparam int REG_STATUS = 0;
  localparam int REG_RXD    = 1;
  localparam int REG_TXD    = 2;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_o      = scl_ff[STAGES-1];
  assign sda_o      = sda_ff[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  // SDA edges with SCL held high on both samples
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = DATA_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sda_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  output logic              sda_oe_o,
  output logic              addr_hit_o,
  output logic              addr_miss_o,
  output logic              addr_rw_o,
  output logic              rx_push_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              tx_load_o,
  output logic              tx_ack_o
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DATA_W - 1);

  tgt_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] sh;
  logic              done, match, rw, mack, oe;
  logic              addr_done;

  assign addr_done   = (state == ST_ADDR) && scl_rise_i && (cnt == CNT_MAX);
  assign addr_hit_o  = addr_done && (sh[ADDR_W-1:0] == own_addr_i);
  assign addr_miss_o = addr_done && (sh[ADDR_W-1:0] != own_addr_i);
  assign addr_rw_o   = sda_i;
  assign rx_push_o   = (state == ST_WR) && scl_fall_i && done;
  assign rx_data_o   = sh;
  assign tx_ack_o    = (state == ST_RACK) && scl_rise_i;
  assign tx_load_o   = scl_fall_i && (((state == ST_ACK) && rw) ||
                                      ((state == ST_RACK) && done && mack));
  assign sda_oe_o    = oe;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state <= ST_IDLE;
      cnt   <= '0;
      sh    <= '0;
      done  <= 1'b0;
      match <= 1'b0;
      rw    <= 1'b0;
      mack  <= 1'b0;
      oe    <= 1'b0;
    end else if (start_i) begin
      state <= ST_ADDR;
      cnt   <= '0;
      done  <= 1'b0;
      oe    <= 1'b0;
    end else if (stop_i) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      oe    <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (scl_rise_i) begin
            sh  <= {sh[DATA_W-2:0], sda_i};
            cnt <= cnt + 1'b1;
            if (cnt == CNT_MAX) begin
              done  <= 1'b1;
              match <= addr_hit_o;
              rw    <= sda_i;
            end
          end else if (scl_fall_i && done) begin
            done  <= 1'b0;
            oe    <= match;
            state <= match ? ST_ACK : ST_IDLE;
          end
        end
        ST_ACK: begin
          if (scl_fall_i) begin
            cnt <= '0;
            if (rw) begin
              sh    <= tx_byte_i;
              oe    <= ~tx_byte_i[DATA_W-1];
              state <= ST_RD;
            end else begin
              oe    <= 1'b0;
              state <= ST_WR;
            end
          end
        end
        ST_WR: begin
          if (scl_rise_i) begin
            sh  <= {sh[DATA_W-2:0], sda_i};
            cnt <= cnt + 1'b1;
            if (cnt == CNT_MAX) done <= 1'b1;
          end else if (scl_fall_i && done) begin
            done  <= 1'b0;
            oe    <= 1'b1;
            state <= ST_ACK;
          end
        end
        ST_RD: begin
          if (scl_rise_i) begin
            cnt <= cnt + 1'b1;
            if (cnt == CNT_MAX) done <= 1'b1;
          end else if (scl_fall_i) begin
            if (done) begin
              done  <= 1'b0;
              oe    <= 1'b0;
              state <= ST_RACK;
            end else begin
              oe <= ~sh[DATA_W-2];
              sh <= {sh[DATA_W-2:0], 1'b0};
            end
          end
        end
        ST_RACK: begin
          if (scl_rise_i) begin
            done <= 1'b1;
            mack <= ~sda_i;
          end else if (scl_fall_i && done) begin
            done <= 1'b0;
            if (mack) begin
              sh    <= tx_byte_i;
              oe    <= ~tx_byte_i[DATA_W-1];
              cnt   <= '0;
              state <= ST_RD;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs
  import i2c_tgt_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int REG_AW = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              addr_hit_i,
  input  logic              addr_miss_i,
  input  logic              addr_rw_i,
  input  logic              stop_i,
  input  logic              rx_push_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              tx_load_i,
  input  logic              tx_ack_i,
  output logic [DATA_W-1:0] tx_byte_o,
  output logic              thr_full_o,
  output logic              act_o,
  output logic              dir_o,
  output logic              eoa_o,
  output logic              rxrdy_o,
  output logic              txrdy_o,
  output logic              undr_o
);
  logic [DATA_W-1:0] rxd, thr;
  logic sel_sts, sel_rxd, sel_txd, sts_rd, end_acc;

  assign sel_sts = reg_addr_i == REG_AW'(REG_STATUS);
  assign sel_rxd = reg_addr_i == REG_AW'(REG_RXD);
  assign sel_txd = reg_addr_i == REG_AW'(REG_TXD);
  assign sts_rd  = reg_rd_i && sel_sts;
  assign end_acc = act_o && (addr_miss_i || stop_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_o      <= 1'b0;
      dir_o      <= 1'b0;
      eoa_o      <= 1'b0;
      rxrdy_o    <= 1'b0;
      txrdy_o    <= 1'b1;
      undr_o     <= 1'b0;
      thr_full_o <= 1'b0;
      rxd        <= '0;
      thr        <= '0;
    end else begin
      if (addr_hit_i) begin
        act_o <= 1'b1;
        dir_o <= addr_rw_i;
      end else if (addr_miss_i || stop_i) begin
        act_o <= 1'b0;
      end

      if (end_acc)     eoa_o <= 1'b1;
      else if (sts_rd) eoa_o <= 1'b0;

      if (tx_load_i && !thr_full_o) undr_o <= 1'b1;
      else if (sts_rd)              undr_o <= 1'b0;

      if (rx_push_i) begin
        rxd     <= rx_data_i;
        rxrdy_o <= 1'b1;
      end else if (reg_rd_i && sel_rxd) begin
        rxrdy_o <= 1'b0;
      end

      if (tx_load_i)     txrdy_o <= 1'b0;
      else if (tx_ack_i) txrdy_o <= 1'b1;

      // a host write in the load cycle lands after the copy
      if (tx_load_i) thr_full_o <= 1'b0;
      if (reg_wr_i && sel_txd) begin
        thr        <= reg_wdata_i;
        thr_full_o <= 1'b1;
      end
    end
  end

  assign tx_byte_o = thr_full_o ? thr : '1;

  always_comb begin
    reg_rdata_o = '0;
    if (sel_sts) begin
      reg_rdata_o[STS_ACT]   = act_o;
      reg_rdata_o[STS_DIR]   = dir_o;
      reg_rdata_o[STS_EOA]   = eoa_o;
      reg_rdata_o[STS_RXRDY] = rxrdy_o;
      reg_rdata_o[STS_TXRDY] = txrdy_o;
      reg_rdata_o[STS_UNDR]  = undr_o;
    end else if (sel_rxd) begin
      reg_rdata_o = rxd;
    end
  end
endmodule

// File: rtl/i2c_target.sv
module i2c_target #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int REG_AW      = 2,
  localparam int ADDR_W     = DATA_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic addr_hit, addr_miss, addr_rw, rx_push, tx_load, tx_ack, thr_full;
  logic sts_act, sts_dir, sts_eoa, sts_rxrdy, sts_txrdy, sts_undr;
  logic [DATA_W-1:0] rx_data, tx_byte;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  i2c_tgt_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk_i, .rst_ni,
    .sda_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det),
    .own_addr_i, .tx_byte_i(tx_byte), .sda_oe_o,
    .addr_hit_o(addr_hit), .addr_miss_o(addr_miss), .addr_rw_o(addr_rw),
    .rx_push_o(rx_push), .rx_data_o(rx_data),
    .tx_load_o(tx_load), .tx_ack_o(tx_ack)
  );

  i2c_tgt_regs #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_regs (
    .clk_i, .rst_ni, .reg_addr_i, .reg_rd_i, .reg_wr_i, .reg_wdata_i,
    .reg_rdata_o,
    .addr_hit_i(addr_hit), .addr_miss_i(addr_miss), .addr_rw_i(addr_rw),
    .stop_i(stop_det), .rx_push_i(rx_push), .rx_data_i(rx_data),
    .tx_load_i(tx_load), .tx_ack_i(tx_ack),
    .tx_byte_o(tx_byte), .thr_full_o(thr_full),
    .act_o(sts_act), .dir_o(sts_dir), .eoa_o(sts_eoa),
    .rxrdy_o(sts_rxrdy), .txrdy_o(sts_txrdy), .undr_o(sts_undr)
  );
endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_s,
  input logic sda_oe_o,
  input logic stop_det,
  input logic addr_hit,
  input logic addr_miss,
  input logic addr_rw,
  input logic rx_push,
  input logic tx_load,
  input logic tx_ack,
  input logic thr_full,
  input logic sts_act,
  input logic sts_dir,
  input logic sts_eoa,
  input logic sts_rxrdy,
  input logic sts_txrdy,
  input logic sts_undr
);
  // R10
  oe_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_s);
  // R2
  hit_sets_act_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_hit |=> sts_act && (sts_dir == $past(addr_rw)));
  // R3
  miss_clears_act_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_miss |=> !sts_act);
  // R5
  stop_clears_act_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sts_act);
  // R5
  fall_sets_eoa_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sts_act) |-> sts_eoa);
  // R4
  push_sets_rxrdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push |=> sts_rxrdy);
  // R7
  load_clears_txrdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load |=> !sts_txrdy);
  // R7
  ack_sets_txrdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_ack |=> sts_txrdy);
  // R8
  empty_load_undr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_load && !thr_full) |=> sts_undr);
endmodule

bind i2c_target i2c_tgt_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s(scl_s), .sda_oe_o(sda_oe_o),
  .stop_det(stop_det), .addr_hit(addr_hit), .addr_miss(addr_miss),
  .addr_rw(addr_rw), .rx_push(rx_push), .tx_load(tx_load), .tx_ack(tx_ack),
  .thr_full(thr_full), .sts_act(sts_act), .sts_dir(sts_dir),
  .sts_eoa(sts_eoa), .sts_rxrdy(sts_rxrdy), .sts_txrdy(sts_txrdy),
  .sts_undr(sts_undr)
);

// File: tb/test_i2c_target.sv
module test_i2c_target;
  localparam int Q = 10;
  localparam logic [6:0] OWN = 7'h2A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [1:0] reg_addr = '0;
  logic reg_rd = 1'b0, reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic sda_line;
  int checks = 0, errors = 0;
  logic oe_prev = 1'b0;

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_target i_i2c_target (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .own_addr_i(OWN), .reg_addr_i(reg_addr),
    .reg_rd_i(reg_rd), .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R10 monitor: the SDA enable moves only while the bench holds SCL low
  always @(negedge clk) begin
    if (rst_n && sda_oe !== oe_prev) chk("R10 oe edge with scl", {7'd0, scl_m}, 8'h00);
    oe_prev <= sda_oe;
  end

  task automatic wq;
    repeat (Q) @(negedge clk);
  endtask

  task automatic peek_sts(output logic [7:0] v);
    @(negedge clk);
    reg_addr = 2'd0;
    #1 v = reg_rdata;
  endtask

  // direction bit is meaningless while inactive: mask it then
  task automatic cmp_sts(input string tag, input logic [7:0] exp);
    logic [7:0] v;
    peek_sts(v);
    if (!exp[0]) begin
      v[1] = 1'b0;
      exp[1] = 1'b0;
    end
    chk(tag, v, exp);
  endtask

  task automatic host_rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    reg_rd = 1'b1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    reg_wdata = d;
    reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bit_x(input logic b, output logic line);
    sda_m = b;   wq;
    scl_m = 1'b1; wq;
    line = sda_line; wq;
    scl_m = 1'b0; wq;
  endtask

  task automatic m_start;
    sda_m = 1'b0; wq;
    scl_m = 1'b0; wq;
  endtask

  task automatic m_rstart;
    sda_m = 1'b1; wq;
    scl_m = 1'b1; wq;
    sda_m = 1'b0; wq;
    scl_m = 1'b0; wq;
  endtask

  task automatic m_stop;
    sda_m = 1'b0; wq;
    scl_m = 1'b1; wq;
    sda_m = 1'b1; wq;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic l;
    for (int i = 7; i >= 0; i--) bit_x(b[i], l);
    bit_x(1'b1, l);
    acked = ~l;
  endtask

  task automatic recv_byte(input logic m_ack, output logic [7:0] d, output logic txr);
    logic l;
    logic [7:0] v;
    for (int i = 0; i < 8; i++) begin
      bit_x(1'b1, l);
      d = {d[6:0], l};
    end
    sda_m = ~m_ack; wq;
    scl_m = 1'b1; wq; wq;
    peek_sts(v);
    txr = v[4];
    scl_m = 1'b0; wq;
    sda_m = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic ack, txr, l, any_low;
    logic [7:0] d;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    cmp_sts("R1 reset status", 8'h10);
    chk("R1 reset sda_oe", {7'd0, sda_oe}, 8'h00);

    // R3 foreign address, never active
    m_start;
    send_byte({7'h15, 1'b0}, ack);
    chk("R3 foreign addr nack", {7'd0, ack}, 8'h00);
    cmp_sts("R3 stays inactive", 8'h10);
    m_stop;
    cmp_sts("R5 stop while inactive no eoa", 8'h10);

    // R2 R4 R5 master write of two bytes
    m_start;
    send_byte({OWN, 1'b0}, ack);
    chk("R2 own addr ack", {7'd0, ack}, 8'h01);
    cmp_sts("R2 active write dir", 8'h11);
    send_byte(8'h5C, ack);
    chk("R4 data ack 1", {7'd0, ack}, 8'h01);
    cmp_sts("R4 rxrdy set", 8'h19);
    host_rd(2'd1, d);
    chk("R4 rx data 1", d, 8'h5C);
    cmp_sts("R4 rxrdy cleared", 8'h11);
    send_byte(8'h81, ack);
    chk("R4 data ack 2", {7'd0, ack}, 8'h01);
    host_rd(2'd1, d);
    chk("R4 rx data 2", d, 8'h81);
    m_stop;
    cmp_sts("R5 stop ends access", 8'h14);
    host_rd(2'd0, d);
    cmp_sts("R5 status read clears eoa", 8'h10);

    // R7 R8 R9 master read running into underrun
    host_wr(2'd2, 8'hA5);
    cmp_sts("R7 txrdy unaffected by write", 8'h10);
    m_start;
    send_byte({OWN, 1'b1}, ack);
    chk("R2 own read addr ack", {7'd0, ack}, 8'h01);
    cmp_sts("R7 load clears txrdy", 8'h03);
    recv_byte(1'b1, d, txr);
    chk("R7 read data msb first", d, 8'hA5);
    chk("R7 txrdy set at master ack", {7'd0, txr}, 8'h01);
    cmp_sts("R8 empty reload underrun", 8'h23);
    recv_byte(1'b0, d, txr);
    chk("R8 empty sends ff", d, 8'hFF);
    chk("R7 txrdy set at master nack", {7'd0, txr}, 8'h01);
    cmp_sts("R9 after nack", 8'h33);
    any_low = 1'b0;
    for (int i = 0; i < 9; i++) begin
      bit_x(1'b1, l);
      if (!l) any_low = 1'b1;
    end
    chk("R9 no drive after nack", {7'd0, any_low}, 8'h00);
    m_stop;
    cmp_sts("R5 stop after read", 8'h34);
    host_rd(2'd0, d);
    cmp_sts("R5 status read clears eoa and underrun", 8'h10);

    // R6 repeated START with own and foreign address
    host_wr(2'd2, 8'h3C);
    m_start;
    send_byte({OWN, 1'b0}, ack);
    cmp_sts("R6 write phase active", 8'h11);
    m_rstart;
    send_byte({OWN, 1'b1}, ack);
    chk("R6 rs own ack", {7'd0, ack}, 8'h01);
    cmp_sts("R6 rs own keeps active dir read", 8'h03);
    recv_byte(1'b0, d, txr);
    chk("R6 read after rs", d, 8'h3C);
    m_rstart;
    send_byte({7'h11, 1'b0}, ack);
    chk("R3 rs foreign nack", {7'd0, ack}, 8'h00);
    cmp_sts("R6 rs foreign ends access", 8'h14);
    m_stop;
    cmp_sts("R6 stop keeps eoa", 8'h14);
    host_rd(2'd0, d);
    cmp_sts("R5 final clear", 8'h10);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule